// File: doc/BRIEF.md
# UART Control and Interrupt Logic

This block holds the control and status part of an asynchronous serial port. It also contains a minimal transmit shifter and a minimal receive shifter. Software reaches it through a byte-wide register bus with four addresses. Through that bus it sets three enable bits, loads the transmit holding register, reads received bytes and clears status flags. The block drives three interrupt lines: one for an empty transmit holding register, one for a filled receive register, and one for any receive error. It also selects what drives the transmit pin. When the transmitter is enabled, the pin carries serial data. When it is disabled, the pin carries a general-purpose output value.

Each line bit lasts one clock. A frame is a low start bit, eight data bits sent least significant first, one parity bit and a high stop bit. Parity is even by default. Setting a parameter makes it odd. The receiver has no enable and always listens. Status flags use a two-step clear. Software must first read a flag as 1 and then write 0 to it.

Register map:
- Address 0 is control. Bit 7 is the transmit interrupt enable, bit 6 the receive interrupt enable and bit 5 the transmit enable.
- Address 1 is the transmit holding register.
- Address 2 is status. Bit 7 is transmit-empty, bit 6 receive-full, bit 5 overrun, bit 4 framing error and bit 3 parity error.
- Address 3 is the receive data register.

Unused bits read as 0.

Top module: `uart_ctl_top`

## Requirements
- R1: After reset all three enable bits read 0. Status (address 2) reads 0x80. All interrupt lines are low. The transmit pin follows `gpio_out`.
- R2: `irq_txe` is high exactly when control bit 7 is 1 and status bit 7 (transmit-empty) is 1. It follows the flag in the same cycle.
- R3: While control bit 5 is 0, the following hold: status bit 7 reads 1; writes to address 1 leave the holding register unchanged; no frame is sent; the transmit pin equals `gpio_out`. Clearing bit 5 during a frame stops that frame.
- R4: With control bit 5 at 1, a write to address 1 clears transmit-empty at that clock edge. At the next edge the byte moves into the shifter and transmit-empty returns to 1. From that edge on, the pin shows one bit per clock: 0, data bits 0 to 7, parity, then 1. The parity bit is the XOR of the data bits for even parity.
- R5: A byte written while a frame is in flight waits in the holding register. Its start bit follows the previous stop bit with no idle clock between them.
- R6: The receiver starts a frame when it samples the line at 0 while idle. At the edge that samples the stop bit, the byte is written to address 3 and status bit 6 (receive-full) is set.
- R7: `irq_rxf` equals control bit 6 AND status bit 6. `irq_rxerr` equals control bit 6 AND the OR of status bits 5, 4 and 3. Clearing control bit 6 drops both lines and leaves the flags unchanged.
- R8: A stop bit sampled as 0 sets status bit 4 (framing error). A parity bit that does not match sets status bit 3 (parity error). In both cases the byte is still stored.
- R9: A frame that completes while receive-full is already 1 sets status bit 5 (overrun). Address 3 keeps its old byte and the framing and parity flags stay unchanged.
- R10: Writing 0 to a flag bit at address 2 clears it only if that flag was read as 1 in an earlier read of address 2. Writing 1 has no effect. A write of 0 with no earlier read also has no effect.
- R11: Reads of address 0 return the written enable bits in positions 7, 6 and 5, with the other bits 0. Reads of address 1 return the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe, arms the flag clear when the status register is read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| rx_in | input | 1 | Serial receive line, idle high |
| gpio_out | input | 1 | Value driven on the pin while the transmitter is off |
| tx_pin | output | 1 | Transmit pin: serial data or general-purpose value |
| irq_txe | output | 1 | Transmit-empty interrupt |
| irq_rxf | output | 1 | Receive-full interrupt |
| irq_rxerr | output | 1 | Receive-error interrupt |

## Verification
Register writes take effect at the edge that samples the strobe. The interrupt lines and read data then follow in the same cycle, because no register sits between the flags and the outputs. A transmit write clears transmit-empty at edge t. The flag refills and the start bit appears after edge t+1, and each later bit follows one edge apart. Receive flags change at the edge that samples the stop bit, which is ten edges after the edge that saw the start bit. The bench updates its behavioural model at each rising edge. It compares every output 2 ns after that edge, and the directed checks sample at those same points.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 3;           // start + data + parity + stop
    localparam int FCNT_W  = $clog2(FRAME_W);
    localparam int DCNT_W  = $clog2(DATA_W);
    localparam int NFLAG   = 4;                    // software-clearable receive flags

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_TXD  = 2'd1,
        A_STAT = 2'd2,
        A_RXD  = 2'd3
    } reg_addr_e;

    // control bit positions
    localparam int C_TXIE = 7;
    localparam int C_RXIE = 6;
    localparam int C_TXEN = 5;
    // status bit positions
    localparam int S_TDRE    = 7;
    localparam int S_FLAG_LO = 3;                  // flags occupy [6:3]

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic txie;
        logic rxie;
        logic txen;
    } ctrl_t;

    // order matches status bits 6..3
    typedef struct packed {
        logic rdrf;
        logic ovr;
        logic fer;
        logic per;
    } rx_flags_t;

    typedef struct packed {
        byte_t data;
        logic  fer;
        logic  per;
    } rx_result_t;

    function automatic logic par_bit(byte_t d, logic odd);
        return (^d) ^ odd;
    endfunction

    // bit 0 leaves the pin first
    function automatic logic [FRAME_W-1:0] build_frame(byte_t d, logic odd);
        return {1'b1, par_bit(d, odd), d, 1'b0};
    endfunction

endpackage

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_ctl_pkg::*;
#(
    parameter bit ODD_PAR = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tx_en,
    input  logic  tx_req,
    input  byte_t tx_byte,
    output logic  tx_take,
    output logic  tx_serial
);
    localparam logic [FCNT_W-1:0] LAST_IDX = FCNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] sh_q;
    logic [FCNT_W-1:0]  left_q;
    logic               busy_q;

    // a new frame loads when idle or on the clock that drops the stop bit
    assign tx_take   = tx_req && (!busy_q || left_q == '0);
    assign tx_serial = busy_q ? sh_q[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sh_q   <= '1;
            left_q <= '0;
        end else if (!tx_en) begin
            busy_q <= 1'b0;
        end else if (tx_take) begin
            sh_q   <= build_frame(tx_byte, ODD_PAR);
            left_q <= LAST_IDX;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (left_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
                left_q <= left_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
    import uart_ctl_pkg::*;
#(
    parameter bit ODD_PAR = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_in,
    output logic       rx_done,
    output rx_result_t rx_res
);
    typedef enum logic [1:0] {RX_IDLE, RX_DATA, RX_PAR, RX_STOP} rx_state_e;

    localparam logic [DCNT_W-1:0] DLAST = DCNT_W'(DATA_W - 1);

    rx_state_e         st_q;
    logic [DCNT_W-1:0] cnt_q;
    byte_t             dat_q;
    logic              par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RX_IDLE;
            cnt_q <= '0;
            dat_q <= '0;
            par_q <= 1'b0;
        end else begin
            case (st_q)
                RX_IDLE: begin
                    if (!rx_in) begin
                        st_q  <= RX_DATA;
                        cnt_q <= '0;
                    end
                end
                RX_DATA: begin
                    dat_q <= {rx_in, dat_q[DATA_W-1:1]};
                    if (cnt_q == DLAST) st_q <= RX_PAR;
                    else                cnt_q <= cnt_q + 1'b1;
                end
                RX_PAR: begin
                    par_q <= rx_in;
                    st_q  <= RX_STOP;
                end
                default: st_q <= RX_IDLE;
            endcase
        end
    end

    // the stop bit is judged live, in the cycle it is on the line
    assign rx_done     = (st_q == RX_STOP);
    assign rx_res.data = dat_q;
    assign rx_res.fer  = !rx_in;
    assign rx_res.per  = (par_q != par_bit(dat_q, ODD_PAR));

endmodule

// File: rtl/uart_ctl_regs.sv
module uart_ctl_regs
    import uart_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  byte_t      bus_wdata,
    output byte_t      bus_rdata,
    output ctrl_t      ctrl_o,
    output logic       tdre_o,
    output logic       tx_req,
    output byte_t      tx_byte,
    input  logic       tx_take,
    input  logic       rx_done,
    input  rx_result_t rx_res,
    output rx_flags_t  flags_o,
    output byte_t      rdr_o,
    output logic       irq_txe,
    output logic       irq_rxf,
    output logic       irq_rxerr
);
    reg_addr_e  addr;
    ctrl_t      ctrl_q;
    byte_t      tdr_q, rdr_q;
    logic       tdre_q, tdre_eff;
    rx_flags_t  flg_q, flg_d;
    logic [NFLAG-1:0] arm_q, clr;
    logic       wr_ctrl, wr_txd, wr_stat, rd_stat;

    assign addr    = reg_addr_e'(bus_addr);
    assign wr_ctrl = bus_wr && addr == A_CTRL;
    assign wr_txd  = bus_wr && addr == A_TXD;
    assign wr_stat = bus_wr && addr == A_STAT;
    assign rd_stat = bus_rd && addr == A_STAT;

    // ---- control ----
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.txie <= bus_wdata[C_TXIE];
            ctrl_q.rxie <= bus_wdata[C_RXIE];
            ctrl_q.txen <= bus_wdata[C_TXEN];
        end
    end

    // ---- transmit holding register ----
    always_ff @(posedge clk) begin
        if (rst) begin
            tdr_q  <= '0;
            tdre_q <= 1'b1;
        end else if (!ctrl_q.txen) begin
            tdre_q <= 1'b1;
        end else begin
            if (tx_take) tdre_q <= 1'b1;
            if (wr_txd) begin
                tdr_q  <= bus_wdata;
                tdre_q <= 1'b0;
            end
        end
    end

    assign tdre_eff = tdre_q | ~ctrl_q.txen;
    assign tx_req   = ctrl_q.txen & ~tdre_q;
    assign tx_byte  = tdr_q;

    // ---- receive flags: read-as-1 then write-0 clearing ----
    assign clr = wr_stat ? (arm_q & ~bus_wdata[S_FLAG_LO +: NFLAG]) : '0;

    always_comb begin
        flg_d = rx_flags_t'(flg_q & ~clr);
        if (rx_done) begin
            if (flg_q.rdrf) begin
                flg_d.ovr = 1'b1;
            end else begin
                flg_d.rdrf = 1'b1;
                flg_d.fer  = flg_d.fer | rx_res.fer;
                flg_d.per  = flg_d.per | rx_res.per;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
            arm_q <= '0;
            rdr_q <= '0;
        end else begin
            flg_q <= flg_d;
            if (rd_stat) arm_q <= flg_q;
            else         arm_q <= arm_q & ~clr;
            if (rx_done && !flg_q.rdrf) rdr_q <= rx_res.data;
        end
    end

    // ---- read mux ----
    always_comb begin
        bus_rdata = '0;
        case (addr)
            A_CTRL: begin
                bus_rdata[C_TXIE] = ctrl_q.txie;
                bus_rdata[C_RXIE] = ctrl_q.rxie;
                bus_rdata[C_TXEN] = ctrl_q.txen;
            end
            A_TXD:  bus_rdata = tdr_q;
            A_STAT: begin
                bus_rdata[S_TDRE]             = tdre_eff;
                bus_rdata[S_FLAG_LO +: NFLAG] = flg_q;
            end
            default: bus_rdata = rdr_q;
        endcase
    end

    // ---- interrupts ----
    assign irq_txe   = ctrl_q.txie & tdre_eff;
    assign irq_rxf   = ctrl_q.rxie & flg_q.rdrf;
    assign irq_rxerr = ctrl_q.rxie & (flg_q.ovr | flg_q.fer | flg_q.per);

    assign ctrl_o  = ctrl_q;
    assign tdre_o  = tdre_q;
    assign flags_o = flg_q;
    assign rdr_o   = rdr_q;

endmodule

// File: rtl/uart_ctl_top.sv
module uart_ctl_top
    import uart_ctl_pkg::*;
#(
    parameter bit ODD_PAR = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_in,
    input  logic       gpio_out,
    output logic       tx_pin,
    output logic       irq_txe,
    output logic       irq_rxf,
    output logic       irq_rxerr
);
    ctrl_t      ctrl_q;
    logic       tdre_q, tx_req, tx_take, tx_serial, rx_done;
    byte_t      tx_byte, rdr_q;
    rx_result_t rx_res;
    rx_flags_t  flg_q;

    uart_ctl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl_o    (ctrl_q),
        .tdre_o    (tdre_q),
        .tx_req    (tx_req),
        .tx_byte   (tx_byte),
        .tx_take   (tx_take),
        .rx_done   (rx_done),
        .rx_res    (rx_res),
        .flags_o   (flg_q),
        .rdr_o     (rdr_q),
        .irq_txe   (irq_txe),
        .irq_rxf   (irq_rxf),
        .irq_rxerr (irq_rxerr)
    );

    uart_tx_shift #(.ODD_PAR(ODD_PAR)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (ctrl_q.txen),
        .tx_req    (tx_req),
        .tx_byte   (tx_byte),
        .tx_take   (tx_take),
        .tx_serial (tx_serial)
    );

    uart_rx_shift #(.ODD_PAR(ODD_PAR)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .rx_in   (rx_in),
        .rx_done (rx_done),
        .rx_res  (rx_res)
    );

    // pin falls back to the general-purpose value while transmit is off
    assign tx_pin = ctrl_q.txen ? tx_serial : gpio_out;

endmodule

// File: rtl/uart_ctl_chk.sv
module uart_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       tx_en,
    input logic       tdre_q,
    input logic       tx_take,
    input logic       rx_done,
    input logic [7:0] rx_data,
    input logic       rdrf,
    input logic       ovr,
    input logic [7:0] rdr
);
    logic wr_txd, wr_stat;
    assign wr_txd  = bus_wr && bus_addr == 2'd1;
    assign wr_stat = bus_wr && bus_addr == 2'd2;

    p_tx_off_refill_r3: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> tdre_q);

    p_txd_write_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_en && wr_txd) |=> !tdre_q);

    p_take_refills_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_take && !wr_txd) |=> tdre_q);

    p_rx_store_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !rdrf) |=> (rdrf && rdr == $past(rx_data)));

    p_overrun_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rdrf) |=> (ovr && $stable(rdr)));

    p_write_one_noop_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && bus_wdata[6] && rdrf) |=> rdrf);

endmodule

bind uart_ctl_top uart_ctl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .tx_en     (ctrl_q.txen),
    .tdre_q    (tdre_q),
    .tx_take   (tx_take),
    .rx_done   (rx_done),
    .rx_data   (rx_res.data),
    .rdrf      (flg_q.rdrf),
    .ovr       (flg_q.ovr),
    .rdr       (rdr_q)
);

// File: tb/tb_uart_ctl_top.sv
module tb_uart_ctl_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_addr;
    logic       bus_wr, bus_rd;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       rx_in, gpio_out;
    logic       tx_pin, irq_txe, irq_rxf, irq_rxerr;

    int errs   = 0;
    int checks = 0;

    always #5 clk = ~clk;

    uart_ctl_top dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_in(rx_in), .gpio_out(gpio_out),
        .tx_pin(tx_pin), .irq_txe(irq_txe), .irq_rxf(irq_rxf), .irq_rxerr(irq_rxerr)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic       m_tie, m_rie, m_ten, m_tdre;
    logic [7:0] m_tdr, m_rdr;
    logic [3:0] m_fl, m_arm;          // {full, overrun, framing, parity}
    logic       txq[$];
    int         ph;
    logic [7:0] acc;
    logic       pbit;

    function automatic logic [10:0] frame_of(input logic [7:0] d);
        return {1'b1, ^d, d, 1'b0};
    endfunction

    always @(posedge clk) begin : model
        logic       o_en, o_tdre, take, done;
        logic [3:0] o_fl, clr;
        logic [7:0] o_tdr;
        logic [10:0] fr;
        if (rst) begin
            m_tie = 0; m_rie = 0; m_ten = 0; m_tdre = 1;
            m_tdr = 0; m_rdr = 0; m_fl = 0; m_arm = 0;
            txq.delete(); ph = 0; acc = 0; pbit = 0;
        end else begin
            o_en = m_ten; o_tdre = m_tdre; o_fl = m_fl; o_tdr = m_tdr;
            // transmitter
            take = o_en && !o_tdre && (txq.size() <= 1);
            if (!o_en) txq.delete();
            else begin
                if (txq.size() > 0) void'(txq.pop_front());
                if (take) begin
                    fr = frame_of(o_tdr);
                    for (int k = 0; k < 11; k++) txq.push_back(fr[k]);
                end
            end
            if (!o_en) m_tdre = 1;
            else begin
                if (take) m_tdre = 1;
                if (bus_wr && bus_addr == 2'd1) begin m_tdr = bus_wdata; m_tdre = 0; end
            end
            if (bus_wr && bus_addr == 2'd0) begin
                m_tie = bus_wdata[7]; m_rie = bus_wdata[6]; m_ten = bus_wdata[5];
            end
            // receiver
            done = 0;
            if (ph == 0) begin
                if (rx_in == 1'b0) ph = 1;
            end else if (ph <= 8) begin
                acc[ph-1] = rx_in; ph++;
            end else if (ph == 9) begin
                pbit = rx_in; ph = 10;
            end else begin
                done = 1; ph = 0;
            end
            // flags
            clr = (bus_wr && bus_addr == 2'd2) ? (m_arm & ~bus_wdata[6:3]) : 4'b0;
            m_fl = o_fl & ~clr;
            if (bus_rd && bus_addr == 2'd2) m_arm = o_fl;
            else                            m_arm = m_arm & ~clr;
            if (done) begin
                if (o_fl[3]) m_fl[2] = 1;
                else begin
                    m_rdr = acc; m_fl[3] = 1;
                    if (!rx_in) m_fl[1] = 1;
                    if (pbit != ^acc) m_fl[0] = 1;
                end
            end
        end
    end

    function automatic logic [7:0] exp_rd();
        case (bus_addr)
            2'd0:    return {m_tie, m_rie, m_ten, 5'b0};
            2'd1:    return m_tdr;
            2'd2:    return {m_tdre | ~m_ten, m_fl, 3'b0};
            default: return m_rdr;
        endcase
    endfunction

    function automatic logic exp_pin();
        if (!m_ten) return gpio_out;
        return (txq.size() != 0) ? txq[0] : 1'b1;
    endfunction

    // every-clock comparison, 2 ns after the rising edge
    always begin
        @(posedge clk);
        #2;
        chk("R11 rdata vs model", bus_rdata, exp_rd());
        chk("R2 irq_txe vs model", {7'b0, irq_txe}, {7'b0, m_tie & (m_tdre | ~m_ten)});
        chk("R7 irq_rxf vs model", {7'b0, irq_rxf}, {7'b0, m_rie & m_fl[3]});
        chk("R7 irq_rxerr vs model", {7'b0, irq_rxerr}, {7'b0, m_rie & (|m_fl[2:0])});
        chk("R4 tx_pin vs model", {7'b0, tx_pin}, {7'b0, exp_pin()});
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rx_frame(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        @(negedge clk) rx_in = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk) rx_in = d[k];
        end
        @(negedge clk) rx_in = (^d) ^ bad_par;
        @(negedge clk) rx_in = !bad_stop;
        @(negedge clk) rx_in = 1'b1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0]  v;
        logic [10:0] fa;
        logic [21:0] f2;
        rst = 1; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
        rx_in = 1; gpio_out = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset state
        #1 chk("R1 pin follows gpio 0", {7'b0, tx_pin}, 8'h00);
        gpio_out = 1;
        #1 chk("R1 pin follows gpio 1", {7'b0, tx_pin}, 8'h01);
        chk("R1 irqs low", {5'b0, irq_txe, irq_rxf, irq_rxerr}, 8'h00);
        rd(2'd0, v); chk("R1 control resets to 0", v, 8'h00);
        rd(2'd2, v); chk("R1 status after reset", v, 8'h80);

        // R3 write while disabled is dropped
        wr(2'd1, 8'h3C);
        rd(2'd1, v); chk("R3 holding reg unchanged while off", v, 8'h00);
        rd(2'd2, v); chk("R3 tdre held at 1", v, 8'h80);

        // R2 interrupt follows enable and the forced flag
        wr(2'd0, 8'h80);
        chk("R2 irq_txe with enable", {7'b0, irq_txe}, 8'h01);
        wr(2'd0, 8'h00);
        chk("R2 irq_txe masked", {7'b0, irq_txe}, 8'h00);

        // R4 single frame
        wr(2'd0, 8'hA0);
        rd(2'd0, v); chk("R11 control readback", v, 8'hA0);
        fa = frame_of(8'hA5);
        @(negedge clk); bus_addr = 2'd1; bus_wdata = 8'hA5; bus_wr = 1;
        @(posedge clk); #2;
        chk("R4 tdre cleared by write", {7'b0, irq_txe}, 8'h00);
        @(negedge clk) bus_wr = 0;
        @(posedge clk); #2;
        chk("R4 tdre refilled on load", {7'b0, irq_txe}, 8'h01);
        chk("R4 start bit", {7'b0, tx_pin}, {7'b0, fa[0]});
        for (int k = 1; k < 11; k++) begin
            @(posedge clk); #2;
            chk("R4 frame bit", {7'b0, tx_pin}, {7'b0, fa[k]});
        end
        @(posedge clk); #2;
        chk("R4 line idle high", {7'b0, tx_pin}, 8'h01);
        rd(2'd1, v); chk("R11 holding readback", v, 8'hA5);

        // R5 back-to-back frames
        f2 = {frame_of(8'h3E), frame_of(8'h96)};
        @(negedge clk); bus_addr = 2'd1; bus_wdata = 8'h96; bus_wr = 1;
        @(posedge clk);
        @(negedge clk) bus_wdata = 8'h3E;
        @(posedge clk); #2;
        chk("R5 first start bit", {7'b0, tx_pin}, {7'b0, f2[0]});
        @(negedge clk) bus_wr = 0;
        for (int k = 1; k < 22; k++) begin
            @(posedge clk); #2;
            chk("R5 gapless frames", {7'b0, tx_pin}, {7'b0, f2[k]});
        end
        @(posedge clk); #2;
        chk("R5 idle after second stop", {7'b0, tx_pin}, 8'h01);

        // R6 / R7 / R10 good frame and clearing
        wr(2'd0, 8'hE0);
        rx_frame(8'h5A, 0, 0);
        chk("R7 irq_rxf raised", {7'b0, irq_rxf}, 8'h01);
        chk("R7 irq_rxerr quiet", {7'b0, irq_rxerr}, 8'h00);
        rd(2'd3, v); chk("R6 received byte", v, 8'h5A);
        wr(2'd2, 8'h00);
        chk("R10 write 0 without read ignored", {7'b0, irq_rxf}, 8'h01);
        rd(2'd2, v); chk("R6 full flag set", v, 8'hC0);
        wr(2'd2, 8'hFF);
        chk("R10 write 1 ignored", {7'b0, irq_rxf}, 8'h01);
        wr(2'd2, 8'h00);
        chk("R10 read then write 0 clears", {7'b0, irq_rxf}, 8'h00);
        rd(2'd2, v); chk("R10 status after clear", v, 8'h80);

        // R8 parity and framing errors
        rx_frame(8'h33, 1, 0);
        rd(2'd2, v); chk("R8 parity error flag", v, 8'hC8);
        chk("R8 irq_rxerr on parity", {7'b0, irq_rxerr}, 8'h01);
        rd(2'd3, v); chk("R8 byte kept on parity error", v, 8'h33);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R10 both flags cleared", v, 8'h80);
        rx_frame(8'h81, 0, 1);
        rd(2'd2, v); chk("R8 framing error flag", v, 8'hD0);
        rd(2'd3, v); chk("R8 byte kept on framing error", v, 8'h81);
        rd(2'd2, v);
        wr(2'd2, 8'h00);

        // R9 overrun
        rx_frame(8'h11, 0, 0);
        rx_frame(8'h22, 0, 0);
        rd(2'd2, v); chk("R9 overrun flag", v, 8'hE0);
        rd(2'd3, v); chk("R9 old byte kept", v, 8'h11);
        chk("R9 irq_rxerr on overrun", {7'b0, irq_rxerr}, 8'h01);

        // R7 disabling receive interrupts
        wr(2'd0, 8'hA0);
        chk("R7 irq_rxf masked", {7'b0, irq_rxf}, 8'h00);
        chk("R7 irq_rxerr masked", {7'b0, irq_rxerr}, 8'h00);
        rd(2'd2, v); chk("R7 flags untouched", v, 8'hE0);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R10 overrun cleared", v, 8'h80);

        // R3 disable mid-frame
        wr(2'd1, 8'h0F);
        repeat (3) @(negedge clk);
        wr(2'd0, 8'h00);
        gpio_out = 0;
        repeat (4) begin
            @(posedge clk); #2;
            chk("R3 pin is gpio after disable", {7'b0, tx_pin}, 8'h00);
        end
        rd(2'd2, v); chk("R3 tdre forced after disable", v, 8'h80);
        gpio_out = 1;
        wr(2'd0, 8'h20);
        repeat (3) begin
            @(posedge clk); #2;
            chk("R3 aborted frame not resumed", {7'b0, tx_pin}, 8'h01);
        end

        repeat (4) @(posedge clk);
        #3 finish_run();
    end

endmodule